// File: doc/BRIEF.md
# Open-Row Favouring DRAM Command Picker

This block sits in front of a single DRAM bank and decides which queued memory request goes out next. Several cores push requests into it. Each request carries a row, a column, a load/store flag and a tag. For a load, the tag is the number of the destination register. Inside the block, each core keeps its pending requests in a small table. The table is indexed by row, and each row entry owns a short FIFO. This lets the block see at once whether a core still has work for the row that is currently open.

The picker keeps issuing from the open row of the current core for as long as that core has work there, up to a capped streak. After that it hands the bank to another core. Cores that raise an urgency flag are served ahead of the plain rotation. A flag can mean that the core has run out of queue room, or that it is stalled on one particular load. A core can also cancel its queued loads to a register that has since been rewritten. Such loads are discarded silently when their turn comes. The DRAM side throttles the picker with a busy input. Each grant produces a single-cycle command strobe.

Top module: `dram_row_sched`

## Requirements
- R1: An enqueue is accepted (`enq_ok` high) exactly when the addressed core already holds fewer than ROW_DEPTH requests for that row and either holds that row already or has fewer than ROW_SLOTS distinct rows pending. A rejected enqueue changes nothing.
- R2: A streak is the number of consecutive issued commands for the same row, counted up to STREAK_CAP. While the streak is below STREAK_CAP and the current core still holds requests for the open row, the next command is taken from that core and row, whatever the urgency flags say.
- R3: When R2 does not apply and no core with pending work has `urg_on` set, the next command goes to the first core with pending work in rotation order. The rotation starts at the core after the current one, wraps, and reaches the current core last. The command uses that core's lowest pending row.
- R4: When R2 does not apply, the first core in the same rotation order that has `urg_on` set and pending work wins. With `urg_load` low, it is served from its lowest pending row.
- R5: For such an urgent core with `urg_load` high, its row field in `urg_row` is served if that row is pending. Otherwise its lowest pending row is served.
- R6: Within one core and row, requests issue in the order they were accepted.
- R7: A `kill_valid` pulse marks every load of core `kill_core` with tag `kill_tag` that is queued at that moment. Queued stores are not marked, and neither are requests accepted in the same cycle. A marked load is removed when selected and never appears on the command outputs. Its removal leaves the open-row and streak state unchanged.
- R8: A command is produced one cycle after a cycle in which `dram_busy` was low and `cmd_valid` was low. `cmd_valid` is therefore never high in two consecutive cycles.
- R9: After reset, and whenever nothing is queued, `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_core | input | CORE_W | Core that owns the request |
| enq_row | input | ROW_W | DRAM row |
| enq_col | input | COL_W | DRAM column |
| enq_store | input | 1 | 1 = store, 0 = load |
| enq_tag | input | TAG_W | Request tag (destination register for loads) |
| enq_ok | output | 1 | Presented enqueue is accepted this cycle |
| kill_valid | input | 1 | Cancel queued loads |
| kill_core | input | CORE_W | Core whose loads are cancelled |
| kill_tag | input | TAG_W | Tag of the loads to cancel |
| urg_on | input | NUM_CORES | Per-core urgency flag |
| urg_load | input | NUM_CORES | Per-core urgency reason: 1 = waits on a load row, 0 = queue room |
| urg_row | input | NUM_CORES*ROW_W | Per-core row of the awaited load, core c at bits c*ROW_W |
| dram_busy | input | 1 | DRAM side cannot accept a command |
| cmd_valid | output | 1 | Command strobe, one cycle per grant |
| cmd_core | output | CORE_W | Core of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_store | output | 1 | Store flag of the command |
| cmd_tag | output | TAG_W | Tag of the command |

## Verification
A corrupted row table shows up as a command with the wrong column or tag. It also shows up as a row served out of order. Either one appears on the very command that should have come from the damaged entry. Errors in the streak counter or in the current-core register do not corrupt any single command. They appear as a wrong core or row at the first hand-off decision. That decision can come up to STREAK_CAP commands later. For that reason the sweeps compare every issued command against the expected sequence instead of checking only totals. A lost or spurious cancel mark appears as an extra or missing command. That in turn shifts every later command of the affected core.

// File: rtl/rds_pkg.sv
// Shared types for the row-aware DRAM request scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rds_pkg;

    // Reason the picker chose its core this cycle.
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_STAY   = 2'd1,
        PICK_URGENT = 2'd2,
        PICK_ROTATE = 2'd3
    } pick_e;

endpackage

// File: rtl/rds_core_queue.sv
// Per-core request store: ROW_SLOTS row entries, each with its own FIFO of
// ROW_DEPTH requests. Offers two row lookups, the lowest pending row, a head
// read by slot and a pop by slot. Loads can be marked dead by tag.
// Assumes ROW_DEPTH is a power of two and ROW_SLOTS >= 2.
module rds_core_queue #(
    parameter int ROW_SLOTS = 8,
    parameter int ROW_DEPTH = 4,
    parameter int ROW_W     = 10,
    parameter int COL_W     = 8,
    parameter int TAG_W     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enq_en,
    input  logic [ROW_W-1:0]                  enq_row,
    input  logic [COL_W-1:0]                  enq_col,
    input  logic                              enq_store,
    input  logic [TAG_W-1:0]                  enq_tag,
    output logic                              enq_ok,
    input  logic                              kill_en,
    input  logic [TAG_W-1:0]                  kill_tag,
    input  logic [ROW_W-1:0]                  qa_row,
    output logic                              qa_hit,
    output logic [$clog2(ROW_SLOTS)-1:0]      qa_slot,
    input  logic [ROW_W-1:0]                  qb_row,
    output logic                              qb_hit,
    output logic [$clog2(ROW_SLOTS)-1:0]      qb_slot,
    output logic                              pend,
    output logic [$clog2(ROW_SLOTS)-1:0]      min_slot,
    input  logic [$clog2(ROW_SLOTS)-1:0]      rd_slot,
    output logic [ROW_W-1:0]                  rd_row,
    output logic [COL_W-1:0]                  rd_col,
    output logic                              rd_store,
    output logic [TAG_W-1:0]                  rd_tag,
    output logic                              rd_dead,
    input  logic                              pop_en,
    input  logic [$clog2(ROW_SLOTS)-1:0]      pop_slot
);
    localparam int SLOT_W = $clog2(ROW_SLOTS);
    localparam int PTR_W  = (ROW_DEPTH > 1) ? $clog2(ROW_DEPTH) : 1;
    localparam int CNT_W  = $clog2(ROW_DEPTH + 1);
    localparam int TOT_W  = $clog2(ROW_SLOTS * ROW_DEPTH + 1);

    logic [ROW_SLOTS-1:0] slot_vld;
    logic [ROW_W-1:0]     slot_row [ROW_SLOTS];
    logic [CNT_W-1:0]     slot_cnt [ROW_SLOTS];
    logic [CNT_W-1:0]     cnt_nxt  [ROW_SLOTS];
    logic [PTR_W-1:0]     rd_ptr   [ROW_SLOTS];
    logic [PTR_W-1:0]     wr_ptr   [ROW_SLOTS];
    logic [COL_W-1:0]     e_col    [ROW_SLOTS][ROW_DEPTH];
    logic                 e_store  [ROW_SLOTS][ROW_DEPTH];
    logic [TAG_W-1:0]     e_tag    [ROW_SLOTS][ROW_DEPTH];
    logic                 e_dead   [ROW_SLOTS][ROW_DEPTH];

    logic              match_hit, free_hit;
    logic [SLOT_W-1:0] match_idx, free_idx, enq_slot;
    logic [ROW_SLOTS-1:0] push_vec, pop_vec;
    logic [TOT_W-1:0]  total;

    // Enqueue lookup: matching row slot first, else lowest free slot.
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        free_hit  = 1'b0;
        free_idx  = '0;
        for (int s = ROW_SLOTS - 1; s >= 0; s--) begin
            if (slot_vld[s] && slot_row[s] == enq_row) begin
                match_hit = 1'b1;
                match_idx = SLOT_W'(s);
            end
            if (!slot_vld[s]) begin
                free_hit = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
        enq_slot = match_hit ? match_idx : free_idx;
        enq_ok   = match_hit ? (slot_cnt[match_idx] < CNT_W'(ROW_DEPTH)) : free_hit;
    end

    // Two independent row lookups used by the picker.
    always_comb begin
        qa_hit  = 1'b0;
        qa_slot = '0;
        qb_hit  = 1'b0;
        qb_slot = '0;
        for (int s = ROW_SLOTS - 1; s >= 0; s--) begin
            if (slot_vld[s] && slot_row[s] == qa_row) begin
                qa_hit  = 1'b1;
                qa_slot = SLOT_W'(s);
            end
            if (slot_vld[s] && slot_row[s] == qb_row) begin
                qb_hit  = 1'b1;
                qb_slot = SLOT_W'(s);
            end
        end
    end

    // Lowest pending row number among occupied slots.
    always_comb begin
        logic [ROW_W-1:0] best;
        logic             seen;
        best     = '0;
        seen     = 1'b0;
        min_slot = '0;
        for (int s = 0; s < ROW_SLOTS; s++) begin
            if (slot_vld[s] && (!seen || slot_row[s] < best)) begin
                seen     = 1'b1;
                best     = slot_row[s];
                min_slot = SLOT_W'(s);
            end
        end
        pend = seen;
    end

    // Head of the slot the picker is looking at.
    always_comb begin
        rd_row   = slot_row[rd_slot];
        rd_col   = e_col[rd_slot][rd_ptr[rd_slot]];
        rd_store = e_store[rd_slot][rd_ptr[rd_slot]];
        rd_tag   = e_tag[rd_slot][rd_ptr[rd_slot]];
        rd_dead  = e_dead[rd_slot][rd_ptr[rd_slot]];
    end

    // Per-slot push/pop strobes and next occupancy.
    always_comb begin
        total = '0;
        for (int s = 0; s < ROW_SLOTS; s++) begin
            push_vec[s] = enq_en && enq_ok && (enq_slot == SLOT_W'(s));
            pop_vec[s]  = pop_en && (pop_slot == SLOT_W'(s));
            cnt_nxt[s]  = slot_cnt[s] + CNT_W'(push_vec[s]) - CNT_W'(pop_vec[s]);
            total       = total + TOT_W'(slot_cnt[s]);
        end
    end

    // Slot control: occupancy, row tag and FIFO pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            for (int s = 0; s < ROW_SLOTS; s++) begin
                slot_row[s] <= '0;
                slot_cnt[s] <= '0;
                rd_ptr[s]   <= '0;
                wr_ptr[s]   <= '0;
            end
        end else begin
            for (int s = 0; s < ROW_SLOTS; s++) begin
                slot_cnt[s] <= cnt_nxt[s];
                slot_vld[s] <= (cnt_nxt[s] != '0);
                if (push_vec[s]) begin
                    slot_row[s] <= enq_row;
                    wr_ptr[s]   <= wr_ptr[s] + PTR_W'(1);
                end
                if (pop_vec[s]) rd_ptr[s] <= rd_ptr[s] + PTR_W'(1);
            end
        end
    end

    // Entry storage: kill marking, then the newly pushed entry.
    always_ff @(posedge clk) begin
        for (int s = 0; s < ROW_SLOTS; s++) begin
            for (int k = 0; k < ROW_DEPTH; k++) begin
                if (kill_en && !e_store[s][k] && e_tag[s][k] == kill_tag)
                    e_dead[s][k] <= 1'b1;
            end
        end
        if (enq_en && enq_ok) begin
            e_col[enq_slot][wr_ptr[enq_slot]]   <= enq_col;
            e_store[enq_slot][wr_ptr[enq_slot]] <= enq_store;
            e_tag[enq_slot][wr_ptr[enq_slot]]   <= enq_tag;
            e_dead[enq_slot][wr_ptr[enq_slot]]  <= 1'b0;
        end
    end

    // R6: pops only ever come from a slot that holds requests.
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (slot_cnt[pop_slot] != '0));

    // R1: a rejected enqueue leaves the stored request count unchanged.
    p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_en && !enq_ok && !pop_en) |=> (total == $past(total)));

endmodule

// File: rtl/rds_pick.sv
// Core picker: decides whether to stay on the open row, or else which core
// wins by urgency or by plain rotation after the current core.
// Assumes per-core pending and open-row-hit flags from the queues.
module rds_pick
    import rds_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic [CORE_W-1:0]    cur_core,
    input  logic                 cur_open,
    input  logic                 streak_full,
    input  logic [NUM_CORES-1:0] pend,
    input  logic [NUM_CORES-1:0] open_hit,
    input  logic [NUM_CORES-1:0] urg_on,
    output logic                 pick_any,
    output logic [CORE_W-1:0]    pick_core,
    output pick_e                pick_kind
);
    logic             stay;
    logic             urg_found, rot_found;
    logic [CORE_W-1:0] urg_core, rot_core;

    // Stay decision for the open row of the current core.
    always_comb begin
        stay = cur_open && !streak_full && open_hit[cur_core];
    end

    // Rotating scan from the core after the current one, current core last.
    always_comb begin
        urg_found = 1'b0;
        rot_found = 1'b0;
        urg_core  = '0;
        rot_core  = '0;
        for (int j = 1; j <= NUM_CORES; j++) begin
            int c;
            c = (int'(cur_core) + j) % NUM_CORES;
            if (!urg_found && urg_on[c] && pend[c]) begin
                urg_found = 1'b1;
                urg_core  = CORE_W'(c);
            end
            if (!rot_found && pend[c]) begin
                rot_found = 1'b1;
                rot_core  = CORE_W'(c);
            end
        end
    end

    // Final choice in priority order: stay, urgent, rotate.
    always_comb begin
        if (stay) begin
            pick_any  = 1'b1;
            pick_core = cur_core;
            pick_kind = PICK_STAY;
        end else if (urg_found) begin
            pick_any  = 1'b1;
            pick_core = urg_core;
            pick_kind = PICK_URGENT;
        end else if (rot_found) begin
            pick_any  = 1'b1;
            pick_core = rot_core;
            pick_kind = PICK_ROTATE;
        end else begin
            pick_any  = 1'b0;
            pick_core = cur_core;
            pick_kind = PICK_NONE;
        end
    end

endmodule

// File: rtl/dram_row_sched.sv
// Row-aware DRAM request scheduler top. Holds one request table per core,
// picks a core and row each free cycle, drops cancelled loads and registers
// the chosen command as a one-cycle strobe. Tracks open row, owner and
// streak length. Assumes dram_busy already reflects any command in flight.
module dram_row_sched
    import rds_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int ROW_SLOTS  = 8,
    parameter int ROW_DEPTH  = 4,
    parameter int ROW_W      = 10,
    parameter int COL_W      = 8,
    parameter int TAG_W      = 5,
    parameter int STREAK_CAP = 5,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [CORE_W-1:0]          enq_core,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [COL_W-1:0]           enq_col,
    input  logic                       enq_store,
    input  logic [TAG_W-1:0]           enq_tag,
    output logic                       enq_ok,
    input  logic                       kill_valid,
    input  logic [CORE_W-1:0]          kill_core,
    input  logic [TAG_W-1:0]           kill_tag,
    input  logic [NUM_CORES-1:0]       urg_on,
    input  logic [NUM_CORES-1:0]       urg_load,
    input  logic [NUM_CORES*ROW_W-1:0] urg_row,
    input  logic                       dram_busy,
    output logic                       cmd_valid,
    output logic [CORE_W-1:0]          cmd_core,
    output logic [ROW_W-1:0]           cmd_row,
    output logic [COL_W-1:0]           cmd_col,
    output logic                       cmd_store,
    output logic [TAG_W-1:0]           cmd_tag
);
    localparam int SLOT_W = $clog2(ROW_SLOTS);
    localparam int STK_W  = $clog2(STREAK_CAP + 1);

    logic [CORE_W-1:0] cur_core;
    logic [ROW_W-1:0]  cur_row;
    logic              cur_open;
    logic [STK_W-1:0]  streak;

    logic [NUM_CORES-1:0] ok_vec, pend, qa_hit, qb_hit, pop_vec;
    logic [SLOT_W-1:0] qa_slot [NUM_CORES];
    logic [SLOT_W-1:0] qb_slot [NUM_CORES];
    logic [SLOT_W-1:0] mn_slot [NUM_CORES];
    logic [SLOT_W-1:0] cand    [NUM_CORES];
    logic [ROW_W-1:0]  h_row   [NUM_CORES];
    logic [COL_W-1:0]  h_col   [NUM_CORES];
    logic              h_store [NUM_CORES];
    logic [TAG_W-1:0]  h_tag   [NUM_CORES];
    logic              h_dead  [NUM_CORES];

    logic              pick_any;
    logic [CORE_W-1:0] pick_core;
    pick_e             pick_kind;
    logic              grant, issue, streak_full;

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CORES; gc++) begin : g_core
            // Candidate slot: open row when staying, awaited row when urgent on a load, else lowest row.
            always_comb begin
                if (pick_kind == PICK_STAY && cur_core == CORE_W'(gc))
                    cand[gc] = qa_slot[gc];
                else if (urg_on[gc] && urg_load[gc] && qb_hit[gc])
                    cand[gc] = qb_slot[gc];
                else
                    cand[gc] = mn_slot[gc];
                pop_vec[gc] = grant && (pick_core == CORE_W'(gc));
            end

            rds_core_queue #(
                .ROW_SLOTS (ROW_SLOTS),
                .ROW_DEPTH (ROW_DEPTH),
                .ROW_W     (ROW_W),
                .COL_W     (COL_W),
                .TAG_W     (TAG_W)
            ) u_queue (
                .clk       (clk),
                .rst_n     (rst_n),
                .enq_en    (enq_valid && enq_core == CORE_W'(gc)),
                .enq_row   (enq_row),
                .enq_col   (enq_col),
                .enq_store (enq_store),
                .enq_tag   (enq_tag),
                .enq_ok    (ok_vec[gc]),
                .kill_en   (kill_valid && kill_core == CORE_W'(gc)),
                .kill_tag  (kill_tag),
                .qa_row    (cur_row),
                .qa_hit    (qa_hit[gc]),
                .qa_slot   (qa_slot[gc]),
                .qb_row    (urg_row[gc*ROW_W +: ROW_W]),
                .qb_hit    (qb_hit[gc]),
                .qb_slot   (qb_slot[gc]),
                .pend      (pend[gc]),
                .min_slot  (mn_slot[gc]),
                .rd_slot   (cand[gc]),
                .rd_row    (h_row[gc]),
                .rd_col    (h_col[gc]),
                .rd_store  (h_store[gc]),
                .rd_tag    (h_tag[gc]),
                .rd_dead   (h_dead[gc]),
                .pop_en    (pop_vec[gc]),
                .pop_slot  (cand[gc])
            );
        end
    endgenerate

    rds_pick #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) u_pick (
        .cur_core    (cur_core),
        .cur_open    (cur_open),
        .streak_full (streak_full),
        .pend        (pend),
        .open_hit    (qa_hit),
        .urg_on      (urg_on),
        .pick_any    (pick_any),
        .pick_core   (pick_core),
        .pick_kind   (pick_kind)
    );

    // Enqueue acceptance of the addressed core; grant and issue qualifiers.
    always_comb begin
        enq_ok      = (int'(enq_core) < NUM_CORES) ? ok_vec[enq_core] : 1'b0;
        streak_full = (streak >= STK_W'(STREAK_CAP));
        grant       = !dram_busy && !cmd_valid && pick_any;
        issue       = grant && !h_dead[pick_core];
    end

    // Command register and open-row / streak tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_core  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_store <= 1'b0;
            cmd_tag   <= '0;
            cur_core  <= '0;
            cur_row   <= '0;
            cur_open  <= 1'b0;
            streak    <= '0;
        end else begin
            cmd_valid <= issue;
            if (issue) begin
                cmd_core  <= pick_core;
                cmd_row   <= h_row[pick_core];
                cmd_col   <= h_col[pick_core];
                cmd_store <= h_store[pick_core];
                cmd_tag   <= h_tag[pick_core];
                cur_core  <= pick_core;
                cur_row   <= h_row[pick_core];
                cur_open  <= 1'b1;
                if (cur_open && h_row[pick_core] == cur_row)
                    streak <= streak_full ? streak : streak + STK_W'(1);
                else
                    streak <= STK_W'(1);
            end
        end
    end

    // R8: one strobe per grant, never two cycles in a row.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8: a command only follows a cycle where the DRAM side was idle.
    p_busy_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(dram_busy));

    // R9: nothing queued means no command next cycle.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !cmd_valid);

    // R2: a live stay decision yields a command on the same core and row.
    p_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && pick_kind == PICK_STAY && !h_dead[pick_core])
        |=> (cmd_valid && cmd_core == $past(cur_core) && cmd_row == $past(cur_row)));

endmodule

// File: tb/dram_row_sched_bench.sv
// Bench: directed and pseudo-random request mixes, drained against a
// reference list model built from the requirements.
module dram_row_sched_bench;
    localparam int NC = 4, SL = 8, DP = 8, RW = 10, CW = 8, TW = 5, CAP = 5;
    localparam int CRW = 2;
    localparam int MAXE = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [CRW-1:0] enq_core = '0;
    logic [RW-1:0] enq_row = '0;
    logic [CW-1:0] enq_col = '0;
    logic enq_store = 1'b0;
    logic [TW-1:0] enq_tag = '0;
    logic enq_ok;
    logic kill_valid = 1'b0;
    logic [CRW-1:0] kill_core = '0;
    logic [TW-1:0] kill_tag = '0;
    logic [NC-1:0] urg_on = '0, urg_load = '0;
    logic [NC*RW-1:0] urg_row = '0;
    logic dram_busy = 1'b1;
    logic cmd_valid;
    logic [CRW-1:0] cmd_core;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic cmd_store;
    logic [TW-1:0] cmd_tag;

    always #2 clk = ~clk;

    dram_row_sched #(.NUM_CORES(NC), .ROW_SLOTS(SL), .ROW_DEPTH(DP), .ROW_W(RW),
                     .COL_W(CW), .TAG_W(TW), .STREAK_CAP(CAP)) u_dram_row_sched (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_core(enq_core),
        .enq_row(enq_row), .enq_col(enq_col), .enq_store(enq_store), .enq_tag(enq_tag),
        .enq_ok(enq_ok), .kill_valid(kill_valid), .kill_core(kill_core), .kill_tag(kill_tag),
        .urg_on(urg_on), .urg_load(urg_load), .urg_row(urg_row), .dram_busy(dram_busy),
        .cmd_valid(cmd_valid), .cmd_core(cmd_core), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_store(cmd_store), .cmd_tag(cmd_tag));

    int n_chk = 0, n_fail = 0, cyc = 0;
    int unsigned rng = 32'h1234_5678;

    // Reference model state.
    int m_n [NC];
    int m_row [NC][MAXE];
    int m_col [NC][MAXE];
    int m_tag [NC][MAXE];
    bit m_st [NC][MAXE];
    bit m_dead [NC][MAXE];
    int cur_c = 0, cur_r = 0, streak = 0;
    bit open_r = 1'b0;
    bit u_on [NC];
    bit u_ld [NC];
    int u_row [NC];
    bit prev_busy = 1'b1, prev_cv = 1'b0;

    function automatic int unsigned rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    function automatic int find_first(int c, int r);
        for (int i = 0; i < m_n[c]; i++) if (m_row[c][i] == r) return i;
        return -1;
    endfunction

    function automatic int low_row(int c);
        int b = 1 << 30;
        for (int i = 0; i < m_n[c]; i++) if (m_row[c][i] < b) b = m_row[c][i];
        return b;
    endfunction

    function automatic int row_count(int c, int r);
        int k = 0;
        for (int i = 0; i < m_n[c]; i++) if (m_row[c][i] == r) k++;
        return k;
    endfunction

    function automatic int distinct_rows(int c);
        int k = 0;
        for (int i = 0; i < m_n[c]; i++) if (find_first(c, m_row[c][i]) == i) k++;
        return k;
    endfunction

    task automatic m_remove(int c, int idx);
        for (int i = idx; i < m_n[c] - 1; i++) begin
            m_row[c][i] = m_row[c][i+1];
            m_col[c][i] = m_col[c][i+1];
            m_tag[c][i] = m_tag[c][i+1];
            m_st[c][i]  = m_st[c][i+1];
            m_dead[c][i] = m_dead[c][i+1];
        end
        m_n[c]--;
    endtask

    // Next visible command per R2..R7; dead loads are removed silently.
    task automatic model_next(output bit has, output int ec, output int er, output int ecol,
                              output int etag, output bit est, output string lbl);
        bit skipped = 1'b0;
        has = 1'b0;
        forever begin
            int tot = 0, c = 0, r = 0, idx;
            bit found = 1'b0;
            for (int k = 0; k < NC; k++) tot += m_n[k];
            if (tot == 0) return;
            if (open_r && streak < CAP && find_first(cur_c, cur_r) >= 0) begin
                c = cur_c; r = cur_r; lbl = "R2"; found = 1'b1;
            end
            for (int j = 1; j <= NC && !found; j++) begin
                int cc = (cur_c + j) % NC;
                if (u_on[cc] && m_n[cc] > 0) begin
                    found = 1'b1; c = cc;
                    if (u_ld[cc] && find_first(cc, u_row[cc]) >= 0) begin
                        r = u_row[cc]; lbl = "R5";
                    end else begin
                        r = low_row(cc); lbl = "R4";
                    end
                end
            end
            for (int j = 1; j <= NC && !found; j++) begin
                int cc = (cur_c + j) % NC;
                if (m_n[cc] > 0) begin
                    found = 1'b1; c = cc; r = low_row(cc); lbl = "R3";
                end
            end
            idx = find_first(c, r);
            if (m_dead[c][idx]) begin
                m_remove(c, idx);
                skipped = 1'b1;
            end else begin
                ec = c; er = r; ecol = m_col[c][idx]; etag = m_tag[c][idx]; est = m_st[c][idx];
                m_remove(c, idx);
                if (open_r && r == cur_r) streak = (streak >= CAP) ? CAP : streak + 1;
                else streak = 1;
                cur_c = c; cur_r = r; open_r = 1'b1;
                lbl = skipped ? {lbl, "/R6/R7"} : {lbl, "/R6"};
                has = 1'b1;
                return;
            end
        end
    endtask

    // One enqueue cycle; checks acceptance against R1.
    task automatic enq(int c, int r, int col, bit st, int tag);
        bit exp_ok;
        int rc = row_count(c, r);
        exp_ok = (rc > 0) ? (rc < DP) : (distinct_rows(c) < SL);
        @(negedge clk);
        enq_valid = 1'b1; enq_core = CRW'(c); enq_row = RW'(r);
        enq_col = CW'(col); enq_store = st; enq_tag = TW'(tag);
        #1;
        chk(enq_ok == exp_ok, "R1", "enq_ok", int'(enq_ok), int'(exp_ok));
        if (exp_ok) begin
            m_row[c][m_n[c]] = r; m_col[c][m_n[c]] = col; m_tag[c][m_n[c]] = tag;
            m_st[c][m_n[c]] = st; m_dead[c][m_n[c]] = 1'b0;
            m_n[c]++;
        end
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    // One cancel cycle (R7).
    task automatic kill(int c, int tag);
        for (int i = 0; i < m_n[c]; i++)
            if (!m_st[c][i] && m_tag[c][i] == tag) m_dead[c][i] = 1'b1;
        @(negedge clk);
        kill_valid = 1'b1; kill_core = CRW'(c); kill_tag = TW'(tag);
        @(negedge clk);
        kill_valid = 1'b0;
    endtask

    task automatic set_urg();
        for (int c = 0; c < NC; c++) begin
            urg_on[c] = u_on[c]; urg_load[c] = u_ld[c];
            urg_row[c*RW +: RW] = RW'(u_row[c]);
        end
    endtask

    // Drain everything queued, busy toggled with probability busy_pct.
    task automatic drain(int busy_pct);
        bit has, est;
        int ec, er, ecol, etag;
        string lbl;
        bit idle_ok;
        set_urg();
        forever begin
            bit seen = 1'b0;
            model_next(has, ec, er, ecol, etag, est, lbl);
            if (!has) break;
            for (int w = 0; w < 400 && !seen; w++) begin
                @(negedge clk);
                if (cmd_valid) begin
                    seen = 1'b1;
                    chk(!prev_busy && !prev_cv, "R8", "gate", int'(prev_busy) * 2 + int'(prev_cv), 0);
                    n_chk++;
                    if (int'(cmd_core) != ec || int'(cmd_row) != er || int'(cmd_col) != ecol ||
                        int'(cmd_tag) != etag || cmd_store != est) begin
                        n_fail++;
                        $display("FAIL %s cmd: actual c%0d r%0d col%0d t%0d s%0d expected c%0d r%0d col%0d t%0d s%0d",
                                 lbl, cmd_core, cmd_row, cmd_col, cmd_tag, cmd_store, ec, er, ecol, etag, est);
                    end
                end
                prev_cv = cmd_valid;
                dram_busy = ((rnd() % 100) < busy_pct);
                prev_busy = dram_busy;
            end
            if (!seen) chk(1'b0, lbl, "command timeout", 0, 1);
        end
        // R9: nothing left, no strobe while idle.
        idle_ok = 1'b1;
        dram_busy = 1'b0;
        for (int w = 0; w < 40; w++) begin
            @(negedge clk);
            if (cmd_valid) idle_ok = 1'b0;
        end
        chk(idle_ok, "R9", "idle cmd_valid", int'(!idle_ok), 0);
        dram_busy = 1'b1;
        @(negedge clk);
        prev_busy = 1'b1; prev_cv = cmd_valid;
        for (int c = 0; c < NC; c++) u_on[c] = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_n[c] = 0; u_on[c] = 1'b0; u_ld[c] = 1'b0; u_row[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R9", "reset cmd_valid", int'(cmd_valid), 0);

        // Streak cap on one core, then rotation (R2, R3, R6).
        for (int i = 0; i < 7; i++) enq(0, 3, i, 1'b0, i);
        enq(0, 1, 40, 1'b1, 1);
        enq(0, 1, 41, 1'b0, 2);
        enq(1, 5, 50, 1'b0, 3);
        enq(1, 5, 51, 1'b1, 4);
        drain(0);

        // Acceptance limits: row FIFO full, then row table full (R1).
        for (int i = 0; i < DP + 1; i++) enq(2, 7, i, 1'b0, 0);
        for (int r = 20; r < 20 + SL; r++) enq(2, r, r, 1'b1, 1);
        drain(30);

        // Urgency by room and by awaited load row (R4, R5).
        for (int c = 0; c < NC; c++) begin
            enq(c, 9, c, 1'b0, 1);
            enq(c, 4, 10 + c, 1'b0, 2);
            enq(c, 12, 20 + c, 1'b1, 3);
        end
        u_on[2] = 1'b1; u_ld[2] = 1'b0;
        u_on[3] = 1'b1; u_ld[3] = 1'b1; u_row[3] = 12;
        u_on[1] = 1'b1; u_ld[1] = 1'b1; u_row[1] = 30;
        drain(20);

        // Cancelled loads are skipped, same-tag stores kept (R7).
        enq(1, 6, 1, 1'b0, 5);
        enq(1, 6, 2, 1'b1, 5);
        enq(1, 6, 3, 1'b0, 5);
        enq(1, 2, 4, 1'b0, 6);
        kill(1, 5);
        enq(1, 6, 5, 1'b0, 5);
        drain(0);

        // Pseudo-random sweeps.
        for (int round = 0; round < 60; round++) begin
            int n = int'(rnd() % 28);
            for (int i = 0; i < n; i++)
                enq(int'(rnd() % NC), int'(rnd() % 6), int'(rnd() % 256),
                    bit'(rnd() % 2), int'(rnd() % 8));
            if (rnd() % 2 == 0) kill(int'(rnd() % NC), int'(rnd() % 8));
            for (int c = 0; c < NC; c++) begin
                u_on[c] = (rnd() % 3 == 0);
                u_ld[c] = bit'(rnd() % 2);
                u_row[c] = int'(rnd() % 7);
            end
            drain(int'(rnd() % 50));
        end

        summary();
        $finish;
    end

endmodule